// File: doc/BRIEF.md
# User-Accessible Network Port with Privilege Steering

This block is a network interface port mapped into a processor's register space so that user code can send and receive messages without a trap into the operating system. Outgoing words are written one at a time into a port register and queued toward the network; each carries the destination last set in a header register, a last-word marker and a privilege flag. The flag comes from the privilege level of the bus access that wrote the word.

Incoming words arrive on a valid/ready stream and wait in an input queue. Each carries its own privilege flag. When the word at the head of the queue is flagged as system traffic, a level interrupt asks privileged code to drain it. User-flagged words stay until the user process reads them through the port. A status register lets software poll the queue state before it reads or writes. The queues are sized for two messages of the typical five-word length.

Top module: `netport_top`

## Requirements
- R1: After reset, status reads 0, `irq` is low, `in_ready` is high and `out_valid` is low.
- R2: A network word is accepted in each cycle in which `in_valid` and `in_ready` are both high. `in_ready` is low while the input queue holds IN_DEPTH (10) words.
- R3: A read of address 3 whose head word is user-flagged returns the head data on `bus_rdata` in the same cycle and removes the word. Words come out in arrival order.
- R4: `irq` is high exactly when the input queue is not empty and its head word is system-flagged. After a privileged read of address 3 pops that word, `irq` drops if the next head is user-flagged or the queue is empty.
- R5: A read of address 3 with `bus_priv` low while the head is system-flagged returns 0, removes nothing and sets the sticky error bit (status bit 4).
- R6: A write to address 0 sets the destination to `bus_wdata[DEST_W-1:0]`. A write to address 1 queues an outgoing word with last=0, and a write to address 2 queues one with last=1. Each queued word carries the current destination and sys=`bus_priv`.
- R7: When the output queue holds OUT_DEPTH (10) words, status bit 1 is set. A write to address 1 or 2 made while the queue is full is dropped, even if a word drains in the same cycle, and it sets the sticky overflow bit (status bit 3).
- R8: The status layout at address 4 is: bit 0 input not empty, bit 1 output full, bit 2 head is system-flagged, bit 3 overflow, bit 4 error, bit 5 head is a last word. Any write to address 4 clears bits 3 and 4.
- R9: A read of address 3 while the input queue is empty returns 0 and changes nothing.
- R10: Outgoing words leave in write order, one per cycle in which `out_valid` and `out_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_priv | input | 1 | Access is privileged (system) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| in_valid | input | 1 | Network word offered |
| in_ready | output | 1 | Input queue can take a word |
| in_sys | input | 1 | Offered word is system-flagged |
| in_last | input | 1 | Offered word ends its message |
| in_data | input | 32 | Offered word payload |
| out_valid | output | 1 | Outgoing word available |
| out_ready | input | 1 | Network takes the outgoing word |
| out_sys | output | 1 | Outgoing word privilege flag |
| out_last | output | 1 | Outgoing word ends its message |
| out_dest | output | 4 | Outgoing word destination |
| out_data | output | 32 | Outgoing word payload |
| irq | output | 1 | System word waiting at the input head |

## Verification
Two pairs of actions can fall in one clock. In the first, a port write reaches a full output queue in the same cycle that the network drains a word. The bench raises `out_ready` and the write strobe together on a full queue. The write must be lost, the overflow bit must set, and exactly the earlier ten words must come out. In the second, a network word arrives in the same cycle that user code pops the input head. The bench judges this from the order and count of the words read back afterwards.

// File: rtl/netport_pkg.sv
package netport_pkg;

    localparam int DATA_W    = 32;
    localparam int DEST_W    = 4;
    localparam int MSG_WORDS = 5;
    localparam int IN_DEPTH  = 2 * MSG_WORDS;
    localparam int OUT_DEPTH = 2 * MSG_WORDS;
    localparam int STAT_W    = 6;

    typedef enum logic [2:0] {
        A_DEST    = 3'd0,
        A_OUT     = 3'd1,
        A_OUTLAST = 3'd2,
        A_IN      = 3'd3,
        A_STAT    = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic              sys;
        logic              last;
        logic [DATA_W-1:0] data;
    } in_word_t;

    typedef struct packed {
        logic              sys;
        logic              last;
        logic [DEST_W-1:0] dest;
        logic [DATA_W-1:0] data;
    } out_word_t;

    typedef struct packed {
        logic head_last;
        logic err;
        logic ovf;
        logic head_sys;
        logic out_full;
        logic in_nonempty;
    } status_t;

    function automatic logic [DATA_W-1:0] widen_status(input status_t s);
        return {{(DATA_W-STAT_W){1'b0}}, s};
    endfunction

endpackage

// File: rtl/np_fifo.sv
module np_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count_q;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign empty = (count_q == '0);
    assign full  = (count_q == CW'(DEPTH));
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            if (push && !pop)      count_q <= count_q + CW'(1);
            else if (!push && pop) count_q <= count_q - CW'(1);
        end
    end

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count_q <= CW'(DEPTH));

    // R7
    push_gate_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    // R10
    pop_gate_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

    // R10
    fill_step_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |=> (count_q == $past(count_q) + CW'(1)));

endmodule

// File: rtl/np_csr.sv
module np_csr
    import netport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_priv,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  in_word_t          in_head,
    input  logic              in_empty,
    output logic              in_pop,
    input  logic              out_full,
    output logic              out_push,
    output out_word_t         out_word,
    output logic              irq
);
    logic [DEST_W-1:0] dest_q;
    logic              ovf_q, err_q;
    logic              rd_in, bad_rd, wr_out, drop, head_sys;
    status_t           stat;

    assign head_sys = !in_empty && in_head.sys;
    assign rd_in    = bus_rd && (bus_addr == A_IN);
    assign in_pop   = rd_in && !in_empty && (bus_priv || !in_head.sys);
    assign bad_rd   = rd_in && head_sys && !bus_priv;
    assign wr_out   = bus_wr && ((bus_addr == A_OUT) || (bus_addr == A_OUTLAST));
    assign out_push = wr_out && !out_full;
    assign drop     = wr_out && out_full;
    assign irq      = head_sys;

    assign out_word.sys  = bus_priv;
    assign out_word.last = (bus_addr == A_OUTLAST);
    assign out_word.dest = dest_q;
    assign out_word.data = bus_wdata;

    assign stat.in_nonempty = !in_empty;
    assign stat.out_full    = out_full;
    assign stat.head_sys    = head_sys;
    assign stat.ovf         = ovf_q;
    assign stat.err         = err_q;
    assign stat.head_last   = !in_empty && in_head.last;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                A_DEST: bus_rdata = {{(DATA_W-DEST_W){1'b0}}, dest_q};
                A_IN:   bus_rdata = in_pop ? in_head.data : '0;
                A_STAT: bus_rdata = widen_status(stat);
                default: bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dest_q <= '0;
            ovf_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == A_DEST) dest_q <= bus_wdata[DEST_W-1:0];
            if (bus_wr && bus_addr == A_STAT) begin
                ovf_q <= 1'b0;
                err_q <= 1'b0;
            end else begin
                if (drop)   ovf_q <= 1'b1;
                if (bad_rd) err_q <= 1'b1;
            end
        end
    end

    // R5
    user_sys_read_chk: assert property (@(posedge clk) disable iff (rst)
        bad_rd |=> err_q);

    // R7
    drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        drop |=> ovf_q);

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(ovf_q) && !$past(bus_wr && bus_addr == A_STAT)) |-> ovf_q);

endmodule

// File: rtl/netport_top.sv
module netport_top
    import netport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_priv,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_sys,
    input  logic              in_last,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_sys,
    output logic              out_last,
    output logic [DEST_W-1:0] out_dest,
    output logic [DATA_W-1:0] out_data,
    output logic              irq
);
    in_word_t  in_word, in_head;
    out_word_t out_word, out_head;
    logic      in_empty, in_full, in_pop;
    logic      out_empty, out_full, out_push, out_pop;

    assign in_word  = '{sys: in_sys, last: in_last, data: in_data};
    assign in_ready = !in_full;

    np_fifo #(.WIDTH($bits(in_word_t)), .DEPTH(IN_DEPTH)) u_in_q (
        .clk(clk), .rst(rst),
        .push(in_valid && !in_full), .push_data(in_word),
        .pop(in_pop), .head(in_head),
        .empty(in_empty), .full(in_full)
    );

    assign out_valid = !out_empty;
    assign out_pop   = out_valid && out_ready;
    assign out_sys   = out_head.sys;
    assign out_last  = out_head.last;
    assign out_dest  = out_head.dest;
    assign out_data  = out_head.data;

    np_fifo #(.WIDTH($bits(out_word_t)), .DEPTH(OUT_DEPTH)) u_out_q (
        .clk(clk), .rst(rst),
        .push(out_push), .push_data(out_word),
        .pop(out_pop), .head(out_head),
        .empty(out_empty), .full(out_full)
    );

    np_csr u_csr (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_priv(bus_priv), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .in_head(in_head), .in_empty(in_empty), .in_pop(in_pop),
        .out_full(out_full), .out_push(out_push), .out_word(out_word),
        .irq(irq)
    );

    // R4
    irq_falls_on_pop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(in_pop));

    // R4
    irq_rises_on_arrival_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(in_valid && in_ready) || $past(in_pop)));

endmodule

// File: tb/netport_top_tb.sv
module netport_top_tb;
    import netport_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [2:0]        bus_addr = '0;
    logic              bus_wr = 1'b0, bus_rd = 1'b0, bus_priv = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0, bus_rdata;
    logic              in_valid = 1'b0, in_ready, in_sys = 1'b0, in_last = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              out_valid, out_ready = 1'b0, out_sys, out_last;
    logic [DEST_W-1:0] out_dest;
    logic [DATA_W-1:0] out_data;
    logic              irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    netport_top u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_priv(bus_priv), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .in_valid(in_valid), .in_ready(in_ready), .in_sys(in_sys), .in_last(in_last),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_sys(out_sys), .out_last(out_last), .out_dest(out_dest),
        .out_data(out_data), .irq(irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_read(input logic [2:0] a, input logic p, output logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_priv = p; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_rd = 1'b0; bus_priv = 1'b0;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic p, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_priv = p; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0; bus_priv = 1'b0;
    endtask

    task automatic net_push(input logic s, input logic l, input logic [DATA_W-1:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_sys = s; in_last = l; in_data = d;
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic out_take(input string tag, input logic s, input logic l,
                            input logic [DEST_W-1:0] dst, input logic [DATA_W-1:0] d);
        @(negedge clk);
        chk({tag, " valid"}, out_valid, 1'b1);
        chk({tag, " word"}, {out_sys, out_last, out_dest, out_data}, {s, l, dst, d});
        out_ready = 1'b1;
        @(posedge clk);
        #1 out_ready = 1'b0;
    endtask

    task automatic t_reset();
        logic [DATA_W-1:0] d;
        bus_read(A_STAT, 1'b0, d);
        chk("R1 status", d, 0);
        chk("R1 irq", irq, 1'b0);
        chk("R1 in_ready", in_ready, 1'b1);
        chk("R1 out_valid", out_valid, 1'b0);
    endtask

    task automatic t_empty_read();
        logic [DATA_W-1:0] d;
        bus_read(A_IN, 1'b1, d);
        chk("R9 empty read data", d, 0);
        bus_read(A_STAT, 1'b0, d);
        chk("R9 status unchanged", d, 0);
    endtask

    task automatic t_user_msg();
        logic [DATA_W-1:0] d;
        for (int i = 0; i < MSG_WORDS; i++) net_push(1'b0, i == MSG_WORDS-1, 32'h100 + i);
        bus_read(A_STAT, 1'b0, d);
        chk("R8 status user head", d, 32'h01);
        chk("R4 irq low for user head", irq, 1'b0);
        for (int i = 0; i < MSG_WORDS; i++) begin
            if (i == MSG_WORDS-1) begin
                bus_read(A_STAT, 1'b0, d);
                chk("R8 head last bit", d, 32'h21);
            end
            bus_read(A_IN, 1'b0, d);
            chk("R3 user read order", d, 32'h100 + i);
        end
        bus_read(A_STAT, 1'b0, d);
        chk("R3 queue drained", d, 0);
    endtask

    task automatic t_sys_msg();
        logic [DATA_W-1:0] d;
        net_push(1'b1, 1'b1, 32'hA5A5);
        net_push(1'b0, 1'b1, 32'h0777);
        @(negedge clk);
        chk("R4 irq on sys head", irq, 1'b1);
        bus_read(A_IN, 1'b0, d);
        chk("R5 user read of sys head data", d, 0);
        bus_read(A_STAT, 1'b0, d);
        chk("R5 error bit and head kept", d, 32'h35);
        bus_read(A_IN, 1'b1, d);
        chk("R4 priv read data", d, 32'hA5A5);
        @(negedge clk);
        chk("R4 irq drops after pop", irq, 1'b0);
        bus_write(A_STAT, 1'b0, 0);
        bus_read(A_STAT, 1'b0, d);
        chk("R8 sticky clear", d, 32'h21);
        bus_read(A_IN, 1'b0, d);
        chk("R3 user word after sys", d, 32'h0777);
    endtask

    task automatic t_in_full();
        logic [DATA_W-1:0] d;
        for (int i = 0; i < IN_DEPTH; i++) net_push(1'b0, 1'b0, 32'h200 + i);
        @(negedge clk);
        chk("R2 in_ready low when full", in_ready, 1'b0);
        net_push(1'b0, 1'b0, 32'hDEAD);
        bus_read(A_IN, 1'b0, d);
        chk("R2 first word", d, 32'h200);
        // R2 concurrent arrival and pop
        @(negedge clk);
        in_valid = 1'b1; in_sys = 1'b0; in_last = 1'b0; in_data = 32'h300;
        bus_addr = A_IN; bus_priv = 1'b0; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 in_valid = 1'b0; bus_rd = 1'b0;
        chk("R3 concurrent pop data", d, 32'h201);
        for (int i = 2; i < IN_DEPTH; i++) begin
            bus_read(A_IN, 1'b0, d);
            chk("R2 remaining order", d, 32'h200 + i);
        end
        bus_read(A_IN, 1'b0, d);
        chk("R2 concurrent arrival kept", d, 32'h300);
        bus_read(A_STAT, 1'b0, d);
        chk("R2 dropped word absent", d, 0);
    endtask

    task automatic t_out();
        bus_write(A_DEST, 1'b0, 32'h5);
        bus_write(A_OUT, 1'b0, 32'h11);
        bus_write(A_OUT, 1'b1, 32'h22);
        bus_write(A_DEST, 1'b0, 32'hB);
        bus_write(A_OUTLAST, 1'b0, 32'h33);
        out_take("R6 word0", 1'b0, 1'b0, 4'h5, 32'h11);
        out_take("R6 word1 sys", 1'b1, 1'b0, 4'h5, 32'h22);
        out_take("R10 word2 last", 1'b0, 1'b1, 4'hB, 32'h33);
        @(negedge clk);
        chk("R10 out empty", out_valid, 1'b0);
    endtask

    task automatic t_out_overflow();
        logic [DATA_W-1:0] d;
        for (int i = 0; i < OUT_DEPTH; i++) bus_write(A_OUT, 1'b0, 32'h400 + i);
        bus_read(A_STAT, 1'b0, d);
        chk("R7 full bit", d, 32'h02);
        // R7 write while full, drained in the same cycle
        @(negedge clk);
        bus_addr = A_OUT; bus_wdata = 32'hBAD; bus_wr = 1'b1; out_ready = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0; out_ready = 1'b0;
        bus_read(A_STAT, 1'b0, d);
        chk("R7 overflow sticky", d, 32'h08);
        for (int i = 1; i < OUT_DEPTH; i++) out_take("R7 kept word", 1'b0, 1'b0, 4'hB, 32'h400 + i);
        @(negedge clk);
        chk("R7 dropped word absent", out_valid, 1'b0);
        bus_write(A_STAT, 1'b0, 0);
        bus_read(A_STAT, 1'b0, d);
        chk("R8 overflow cleared", d, 0);
    endtask

    initial begin
        #500000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_empty_read();
        t_user_msg();
        t_sys_msg();
        t_in_full();
        t_out();
        t_out_overflow();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule